// File: doc/BRIEF.md
# Two-Scale Gaussian Smoother with Difference Output

This block takes a raster stream of 8-bit pixels, one pixel per accepted clock, and smooths it twice with the same symmetric 7-tap kernel. Each smoothing pass is separable. A horizontal pass runs on each incoming row. A vertical pass then combines the current row result with six earlier row results held in line banks. The second pass takes the first pass's output image as its input, so the two passes form a cascade of two blur levels.

For each position where both passes have a full 7×7 support, the block outputs both smoothed values and their difference. The difference is the second-level value minus the first-level value, coded as a sign bit and a 5-bit magnitude that saturates. Each result carries the raw image coordinates of its centre. The first-level value is held in a delay line so that it lines up with the second level. Frames follow one another with no gap. The width and height of a frame are parameters. The input may pause for any number of cycles by holding `valid_i` low.

The kernel is set by parameters. The centre tap and the two inner pairs use coefficients with 8 fraction bits. The outer pair has the value 0 or 1 LSB and is added without a multiplier. The defaults are 1, 12, 55, 120, 55, 12, 1, which sum to 256.

Top module: `gauss_dog_cascade`

## Requirements
- R1: `sm0_o` equals the first-level value at (`x_o`,`y_o`). This value is the horizontal 7-tap sum of the input pixels, followed by the vertical 7-tap sum of those row sums. The total is rounded half up by adding 2^15 and keeping bits [23:16].
- R2: `sm1_o` equals the same two-pass filter, with the same rounding, applied to the first-level image at the same centre.
- R3: `dog_o[5]` is 1 exactly when `sm1_o` < `sm0_o`. `dog_o[4:0]` is |`sm1_o` − `sm0_o`| when that value is at most 31. Equal values give `dog_o` = 0.
- R4: When |`sm1_o` − `sm0_o`| ≥ 32, `dog_o[4:0]` is 31 and the sign bit still follows R3.
- R5: `x_o` and `y_o` are the raw coordinates of the output centre. Outputs come in raster order, with x from 6 to IMG_W−7 and y from 6 to IMG_H−7.
- R6: Each frame produces exactly (IMG_W−12)·(IMG_H−12) results, and `valid_o` is high only for those results.
- R7: Cycles with `valid_i` low are ignored and leave every result value unchanged.
- R8: While reset is held, and until the first qualifying input arrives, `valid_o` stays low.
- R9: The result for centre (X,Y) appears in the cycle after the third rising edge that follows the edge that captured input pixel (X+6,Y+6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input pixel qualifier |
| pix_i | input | 8 | Input pixel, raster order |
| valid_o | output | 1 | Result qualifier |
| x_o | output | $clog2(IMG_W) | Raw column of the result centre |
| y_o | output | $clog2(IMG_H) | Raw row of the result centre |
| sm0_o | output | 8 | First-level smoothed pixel |
| sm1_o | output | 8 | Second-level smoothed pixel |
| dog_o | output | 6 | Difference: sign in bit 5, saturated magnitude in bits 4:0 |

## Verification
The second-level filter can emit a result in the same cycle that a new first-level sample shifts into the alignment delay line. If the tap were read after the shift, the difference would pair values from the wrong positions. Back-to-back input drives this case on almost every cycle. A third frame with regular idle gaps moves the two events apart. In both cases every result is compared against a behavioural two-pass convolution, and the cycle of each result is checked against the cycle in which its source pixel was captured.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int unsigned PIX_W     = 8;
  localparam int unsigned FRAC      = 8;
  localparam int unsigned TAPS      = 7;
  localparam int unsigned HALF      = TAPS / 2;
  localparam int unsigned DOG_MAG_W = 5;
  localparam int unsigned KDEF1     = 12;
  localparam int unsigned KDEF2     = 55;
  localparam int unsigned KDEF3     = 120;
endpackage

// File: rtl/gk_sym_fir.sv
module gk_sym_fir
  import gk_pkg::*;
#(
  parameter int unsigned IN_W    = 8,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned K1      = KDEF1,
  parameter int unsigned K2      = KDEF2,
  parameter int unsigned K3      = KDEF3,
  parameter bit          END_ONE = 1'b1
) (
  input  logic [TAPS-1:0][IN_W-1:0] tap_i,
  output logic [OUT_W-1:0]          sum_o
);
  logic [IN_W:0]    s1, s2;
  logic [OUT_W-1:0] p1, p2, p3, pe;

  // fold mirrored taps before the shared multiplier
  assign s1 = {1'b0, tap_i[1]} + {1'b0, tap_i[5]};
  assign s2 = {1'b0, tap_i[2]} + {1'b0, tap_i[4]};
  assign p1 = OUT_W'(s1) * OUT_W'(K1);
  assign p2 = OUT_W'(s2) * OUT_W'(K2);
  assign p3 = OUT_W'(tap_i[3]) * OUT_W'(K3);

  // outer pair weighs 0 or 1 LSB: plain add, no multiplier
  generate
    if (END_ONE) begin : g_end_add
      logic [IN_W:0] s0;
      assign s0 = {1'b0, tap_i[0]} + {1'b0, tap_i[6]};
      assign pe = OUT_W'(s0);
    end else begin : g_end_zero
      assign pe = '0;
    end
  endgenerate

  assign sum_o = p1 + p2 + p3 + pe;
endmodule

// File: rtl/gk_pass.sv
module gk_pass
  import gk_pkg::*;
#(
  parameter int unsigned IMG_W   = 32,
  parameter int unsigned IMG_H   = 16,
  parameter int unsigned K1      = KDEF1,
  parameter int unsigned K2      = KDEF2,
  parameter int unsigned K3      = KDEF3,
  parameter bit          END_ONE = 1'b1,
  parameter int unsigned CW      = $clog2(IMG_W),
  parameter int unsigned RW      = $clog2(IMG_H)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_o,
  output logic [CW-1:0]    x_o,
  output logic [RW-1:0]    y_o
);
  localparam int unsigned ROW_W = PIX_W + FRAC;
  localparam int unsigned COL_W = ROW_W + FRAC;
  localparam int unsigned LB_W  = IMG_W - (TAPS - 1);
  localparam int unsigned RND   = 1 << (2 * FRAC - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);
  localparam logic [CW-1:0] COL_MIN  = CW'(TAPS - 1);
  localparam logic [RW-1:0] ROW_MIN  = RW'(TAPS - 1);
  localparam logic [CW-1:0] X_HI     = CW'(IMG_W - 1 - HALF);
  localparam logic [RW-1:0] Y_HI     = RW'(IMG_H - 1 - HALF);

  logic [CW-1:0]    col_q;
  logic [RW-1:0]    row_q;
  logic [PIX_W-1:0] hs_q [TAPS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      for (int i = 0; i < TAPS - 1; i++) hs_q[i] <= '0;
    end else if (valid_i) begin
      hs_q[0] <= pix_i;
      for (int i = 1; i < TAPS - 1; i++) hs_q[i] <= hs_q[i-1];
      if (col_q == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  // horizontal pass
  logic [TAPS-1:0][PIX_W-1:0] rtap;
  logic [ROW_W-1:0]           rsum;

  always_comb begin
    rtap[0] = pix_i;
    for (int k = 1; k < TAPS; k++) rtap[k] = hs_q[k-1];
  end

  gk_sym_fir #(
    .IN_W(PIX_W), .OUT_W(ROW_W), .K1(K1), .K2(K2), .K3(K3), .END_ONE(END_ONE)
  ) u_row (
    .tap_i(rtap), .sum_o(rsum)
  );

  logic             rv_q;
  logic [ROW_W-1:0] rsum_q;
  logic [CW-1:0]    ridx_q;
  logic [RW-1:0]    rrow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q   <= 1'b0;
      rsum_q <= '0;
      ridx_q <= '0;
      rrow_q <= '0;
    end else begin
      rv_q <= valid_i && (col_q >= COL_MIN);
      if (valid_i) begin
        rsum_q <= rsum;
        ridx_q <= col_q - COL_MIN;
        rrow_q <= row_q;
      end
    end
  end

  // vertical line banks: chain[k] is the row result k rows back
  logic [ROW_W-1:0] chain [TAPS];
  assign chain[0] = rsum_q;

  for (genvar k = 0; k < TAPS - 1; k++) begin : g_bank
    logic [ROW_W-1:0] mem_q [LB_W];
    assign chain[k+1] = mem_q[ridx_q];
    always_ff @(posedge clk_i) begin
      if (rv_q) mem_q[ridx_q] <= chain[k];
    end
  end

  logic [TAPS-1:0][ROW_W-1:0] ctap;
  logic [COL_W-1:0]           csum;
  logic [PIX_W-1:0]           pix_nx;

  always_comb begin
    for (int k = 0; k < TAPS; k++) ctap[k] = chain[k];
  end

  gk_sym_fir #(
    .IN_W(ROW_W), .OUT_W(COL_W), .K1(K1), .K2(K2), .K3(K3), .END_ONE(END_ONE)
  ) u_col (
    .tap_i(ctap), .sum_o(csum)
  );

  assign pix_nx = PIX_W'((csum + COL_W'(RND)) >> (2 * FRAC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      valid_o <= rv_q && (rrow_q >= ROW_MIN);
      if (rv_q) begin
        pix_o <= pix_nx;
        x_o   <= ridx_q + CW'(HALF);
        y_o   <= rrow_q - RW'(HALF);
      end
    end
  end

  p_center_x_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (x_o >= CW'(HALF) && x_o <= X_HI));
  p_center_y_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (y_o >= RW'(HALF) && y_o <= Y_HI));
  p_pipe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(rv_q));
endmodule

// File: rtl/gk_delay.sv
module gk_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 81
) (
  input  logic         clk_i,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] tap_o
);
  logic [W-1:0] dl_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      dl_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) dl_q[i] <= dl_q[i-1];
    end
  end

  // read before the shift of the same edge
  assign tap_o = dl_q[DEPTH-1];
endmodule

// File: rtl/gk_dog_sat.sv
module gk_dog_sat
  import gk_pkg::*;
#(
  parameter int unsigned MAG_W = DOG_MAG_W
) (
  input  logic [PIX_W-1:0] hi_i,
  input  logic [PIX_W-1:0] lo_i,
  output logic [MAG_W:0]   code_o
);
  localparam int unsigned MAXM = (1 << MAG_W) - 1;

  logic signed [PIX_W:0] diff;
  logic [PIX_W:0]        mag;

  assign diff   = $signed({1'b0, hi_i}) - $signed({1'b0, lo_i});
  assign mag    = diff[PIX_W] ? (PIX_W+1)'(-diff) : diff;
  assign code_o = {diff[PIX_W], (mag > (PIX_W+1)'(MAXM)) ? MAG_W'(MAXM) : mag[MAG_W-1:0]};
endmodule

// File: rtl/gauss_dog_cascade.sv
module gauss_dog_cascade
  import gk_pkg::*;
#(
  parameter int unsigned IMG_W   = 32,
  parameter int unsigned IMG_H   = 16,
  parameter int unsigned K1      = KDEF1,
  parameter int unsigned K2      = KDEF2,
  parameter int unsigned K3      = KDEF3,
  parameter bit          END_ONE = 1'b1,
  parameter int unsigned CW      = $clog2(IMG_W),
  parameter int unsigned RW      = $clog2(IMG_H)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [PIX_W-1:0]     pix_i,
  output logic                 valid_o,
  output logic [CW-1:0]        x_o,
  output logic [RW-1:0]        y_o,
  output logic [PIX_W-1:0]     sm0_o,
  output logic [PIX_W-1:0]     sm1_o,
  output logic [DOG_MAG_W:0]   dog_o
);
  localparam int unsigned W1  = IMG_W - (TAPS - 1);
  localparam int unsigned H1  = IMG_H - (TAPS - 1);
  localparam int unsigned CW1 = $clog2(W1);
  localparam int unsigned RW1 = $clog2(H1);
  localparam int unsigned DLY = HALF * W1 + HALF;

  logic             g0_v, g1_v;
  logic [PIX_W-1:0] g0, g1, g0_dl;
  logic [CW-1:0]    x0;
  logic [RW-1:0]    y0;
  logic [CW1-1:0]   x1;
  logic [RW1-1:0]   y1;
  logic [PIX_W-1:0] al1_q, al2_q;

  gk_pass #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .K1(K1), .K2(K2), .K3(K3), .END_ONE(END_ONE)
  ) u_lvl0 (
    .clk_i, .rst_ni, .valid_i, .pix_i,
    .valid_o(g0_v), .pix_o(g0), .x_o(x0), .y_o(y0)
  );

  gk_pass #(
    .IMG_W(W1), .IMG_H(H1), .K1(K1), .K2(K2), .K3(K3), .END_ONE(END_ONE)
  ) u_lvl1 (
    .clk_i, .rst_ni, .valid_i(g0_v), .pix_i(g0),
    .valid_o(g1_v), .pix_o(g1), .x_o(x1), .y_o(y1)
  );

  gk_delay #(.W(PIX_W), .DEPTH(DLY)) u_align (
    .clk_i, .en_i(g0_v), .d_i(g0), .tap_o(g0_dl)
  );

  // two stages to match the second level's pipeline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al1_q <= '0;
      al2_q <= '0;
    end else begin
      al1_q <= g0_dl;
      al2_q <= al1_q;
    end
  end

  gk_dog_sat #(.MAG_W(DOG_MAG_W)) u_dog (
    .hi_i(g1), .lo_i(al2_q), .code_o(dog_o)
  );

  assign valid_o = g1_v;
  assign sm0_o   = al2_q;
  assign sm1_o   = g1;
  assign x_o     = CW'(x1) + CW'(HALF);
  assign y_o     = RW'(y1) + RW'(HALF);

  p_dog_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sm0_o == sm1_o) |-> (dog_o == '0));
  p_dog_pos_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sm1_o > sm0_o) |-> !dog_o[DOG_MAG_W]);
  p_dog_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ((int'(sm1_o) - int'(sm0_o) >= 32) || (int'(sm0_o) - int'(sm1_o) >= 32)))
      |-> (dog_o[DOG_MAG_W-1:0] == '1));
  p_lvl0_span_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    g0_v |-> (x0 >= CW'(HALF) && y0 >= RW'(HALF)));
endmodule

// File: tb/gauss_dog_cascade_tb_top.sv
module gauss_dog_cascade_tb_top;
  localparam int W  = 32;
  localparam int H  = 16;
  localparam int NF = 3;
  localparam int CW = $clog2(W);
  localparam int RW = $clog2(H);

  typedef struct {
    int f; int x; int y; int s0; int s1; int dog; int ad;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          valid_i;
  logic [7:0]    pix_i;
  logic          valid_o;
  logic [CW-1:0] x_o;
  logic [RW-1:0] y_o;
  logic [7:0]    sm0_o, sm1_o;
  logic [5:0]    dog_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nout   = 0;
  int sat_seen = 0;
  int neg_seen = 0;
  int img    [NF][H][W];
  int cyc_in [NF][H][W];
  int kk [7] = '{1, 12, 55, 120, 55, 12, 1};
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gauss_dog_cascade #(.IMG_W(W), .IMG_H(H)) dut_i (
    .clk_i(clk), .rst_ni, .valid_i, .pix_i,
    .valid_o, .x_o, .y_o, .sm0_o, .sm1_o, .dog_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v);
    return (v > 31) ? 31 : v;
  endfunction

  task automatic build_ref(input int f);
    int r0 [H][W];
    int g0 [H][W];
    int r1 [H][W];
    for (int y = 0; y < H; y++)
      for (int x = 3; x < W - 3; x++) begin
        r0[y][x] = 0;
        for (int j = 0; j < 7; j++) r0[y][x] += kk[j] * img[f][y][x+j-3];
      end
    for (int y = 3; y < H - 3; y++)
      for (int x = 3; x < W - 3; x++) begin
        int s = 0;
        for (int i = 0; i < 7; i++) s += kk[i] * r0[y+i-3][x];
        g0[y][x] = (s + 32768) >>> 16;
      end
    for (int y = 3; y < H - 3; y++)
      for (int x = 6; x < W - 6; x++) begin
        r1[y][x] = 0;
        for (int j = 0; j < 7; j++) r1[y][x] += kk[j] * g0[y][x+j-3];
      end
    for (int y = 6; y < H - 6; y++)
      for (int x = 6; x < W - 6; x++) begin
        exp_t e;
        int s = 0;
        int d;
        for (int i = 0; i < 7; i++) s += kk[i] * r1[y+i-3][x];
        e.f = f; e.x = x; e.y = y;
        e.s0 = g0[y][x];
        e.s1 = (s + 32768) >>> 16;
        d = e.s1 - e.s0;
        e.ad = (d < 0) ? -d : d;
        e.dog = ((d < 0) ? 32 : 0) + clampi(e.ad);
        q.push_back(e);
      end
  endtask

  task automatic monitor();
    if (valid_o) begin
      nout++;
      if (q.size() == 0) begin
        chk(1'b0, "R6 surplus result", nout, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(x_o) == e.x, "R5 x", int'(x_o), e.x);
        chk(int'(y_o) == e.y, "R5 y", int'(y_o), e.y);
        chk(int'(sm0_o) == e.s0, "R1 level0", int'(sm0_o), e.s0);
        chk(int'(sm1_o) == e.s1, "R2 level1", int'(sm1_o), e.s1);
        if (e.ad >= 32) begin
          sat_seen++;
          chk(int'(dog_o) == e.dog, "R4 clamp", int'(dog_o), e.dog);
        end else begin
          chk(int'(dog_o) == e.dog, "R3 dog", int'(dog_o), e.dog);
        end
        if (e.s1 < e.s0) neg_seen++;
        chk(cyc - cyc_in[e.f][e.y+6][e.x+6] == 4, "R9 latency",
            cyc - cyc_in[e.f][e.y+6][e.x+6], 4);
        if (e.f == 2) chk(int'(dog_o) == e.dog && int'(sm1_o) == e.s1,
                          "R7 gapped frame", int'(sm1_o), e.s1);
      end
    end
  endtask

  task automatic step(input logic v, input int p);
    @(negedge clk);
    monitor();
    valid_i = v;
    pix_i   = 8'(p);
  endtask

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    pix_i   = '0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        img[0][y][x] = int'($urandom_range(0, 255));
        img[1][y][x] = (x == 15) ? 255 : 0;
        img[2][y][x] = ((x % 8) < 4) ? 240 : 10;
      end
    img[1][8][10] = 255;
    img[1][7][22] = 200;
    for (int y = 9; y < 12; y++)
      for (int x = 20; x < 23; x++) img[1][y][x] = 180;
    for (int f = 0; f < NF; f++) build_ref(f);

    repeat (3) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R8 in reset", int'(valid_o), 0);
    end
    rst_ni = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(valid_o == 1'b0, "R8 after reset", int'(valid_o), 0);
    end

    for (int f = 0; f < NF; f++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) begin
          if (f == 2 && ((x + y) % 3 == 0)) step(1'b0, 0);
          step(1'b1, img[f][y][x]);
          cyc_in[f][y][x] = cyc;
        end
    step(1'b0, 0);
    repeat (30) step(1'b0, 0);

    chk(nout == NF * (W - 12) * (H - 12), "R6 result count", nout, NF * (W - 12) * (H - 12));
    chk(q.size() == 0, "R6 missing results", q.size(), 0);
    chk(sat_seen > 0, "R4 clamp exercised", sat_seen, 1);
    chk(neg_seen > 0, "R3 negative exercised", neg_seen, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule